// File: doc/BRIEF.md
# Serial Command Interface for a Display Controller

This block is the host-facing port of a fluorescent display controller. A host CPU talks to it over a three-wire synchronous serial link framed by an active-low chip select. The block runs from the system clock. It samples the serial clock and the data line at half the system rate and accepts a new level only when two successive samples agree, so short spikes are filtered out. Bytes arrive least significant bit first. The first complete byte of each frame is a command. The top bits of that command choose one of four kinds: a display-data setting, a display-state setting, a digit start selection, or a port data load.

Three of the command kinds are single-byte settings. They update decoded configuration outputs and the eight general-purpose port latches. The display-data command also sets the segment and digit counts, and it opens a burst. Every later byte in the same frame becomes a display RAM write, with an address that starts at zero and counts up. While the burst runs, the block sends analog-conversion result bytes back to the host on the serial output, one byte per received byte, in index order. The serial output carries an enable that is low whenever the frame is closed.

Top module: `fld_serial_ctrl`

## Requirements
- R1: `sdo_en` is 0 during reset and while `cs_n` is high. It is 1 while `cs_n` is held low.
- R2: A pulse on `sclk` shorter than one sample period (two system clocks) is ignored, so a byte sent with such spikes decodes exactly like a clean one.
- R3: Data is captured on the filtered rising edge of `sclk`. The first bit of a byte is bit 0 and the eighth bit is bit 7.
- R4: A command with bits [7:5]=110 sets `disp_on` from bit 0 and `duty` from bits [2:1].
- R5: A command with bits [7:5]=101 sets `dig_start` from bits [3:0].
- R6: A command with bits [7:5]=100 loads bits [3:0] into `port_out[3:0]` when bit 4 is 0, or into `port_out[7:4]` when bit 4 is 1. The other half is left unchanged.
- R7: A command with bits [7:5]=111 sets `seg_wide` from bit 0 and `dig_cnt` from bits [2:1]. Each later byte in that frame gives one `ram_we` pulse, with `ram_wdata` equal to the byte and `ram_addr` starting at 0 and increasing by one per byte.
- R8: During a burst, `sdo` changes on the filtered falling edge of `sclk`. For the k-th data byte it presents bits 0..7 of `ad_bytes[8k+7:8k]`, so the host can sample each bit before the rising edge that captures the matching input bit. For k of 6 or more, `sdo` is 0.
- R9: After a single-byte command, further bytes in the same frame change no output and cause no RAM write.
- R10: A first byte with bit 7 equal to 0 changes no output.
- R11: If `cs_n` rises before a byte is complete, the partial byte is discarded. The next frame starts with a fresh command byte.
- R12: After reset, all configuration outputs, `port_out`, `sdo` and `ram_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the host, idle high |
| sdi | input | 1 | Serial data from the host |
| ad_bytes | input | 48 | Conversion results; byte k is bits [8k+7:8k] |
| sdo | output | 1 | Serial data to the host |
| sdo_en | output | 1 | Output enable for the serial data driver |
| seg_wide | output | 1 | Segment-count setting |
| dig_cnt | output | 2 | Digit-count setting |
| disp_on | output | 1 | Display enable |
| duty | output | 2 | Dimming duty code |
| dig_start | output | 4 | Digit start code |
| port_out | output | 8 | General-purpose port latches |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | 6 | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |

## Verification
Each command kind is sent with asymmetric field values, so a reversed bit order or a shifted field gives a visibly different register value. The two port loads show whether the select bit picks the right half and leaves the other half alone. A display burst longer than six bytes checks the write sequence and the returned result bytes, both inside and beyond the defined index range, and a second burst shows that the address restarts. Spiked clocks, trailing bytes after a setting, an unknown header and a frame cut off mid-byte each show whether the block rejects input it must not act on.

// File: rtl/fld_ser_pkg.sv
package fld_ser_pkg;

    typedef enum logic [1:0] {
        FR_CMD  = 2'd0,
        FR_DATA = 2'd1,
        FR_SKIP = 2'd2
    } frame_st_e;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_DISP  = 3'd1,
        CMD_STATE = 3'd2,
        CMD_DIGIT = 3'd3,
        CMD_PORT  = 3'd4
    } cmd_kind_e;

    typedef struct packed {
        logic       seg_wide;
        logic [1:0] dig_cnt;
        logic       disp_on;
        logic [1:0] duty;
        logic [3:0] dig_start;
        logic [7:0] port;
    } ctrl_regs_t;

    // Longest header first; the two-bit header only matches what is left.
    function automatic cmd_kind_e decode_header(input logic [7:0] b);
        cmd_kind_e k;
        if (b[7:5] == 3'b111)      k = CMD_DISP;
        else if (b[7:5] == 3'b110) k = CMD_STATE;
        else if (b[7:5] == 3'b100) k = CMD_PORT;
        else if (b[7:6] == 2'b10)  k = CMD_DIGIT;
        else                       k = CMD_NONE;
        return k;
    endfunction

endpackage

// File: rtl/fld_in_filter.sv
module fld_in_filter #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    output logic filt
);
    logic [1:0] sync_q;
    logic       smp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {2{RST_VAL}};
            smp_q  <= RST_VAL;
            filt   <= RST_VAL;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (tick) begin
                smp_q <= sync_q[1];
                if (sync_q[1] == smp_q)
                    filt <= sync_q[1];
            end
        end
    end

    // R2
    filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(filt));

endmodule

// File: rtl/fld_ser_frame.sv
module fld_ser_frame
    import fld_ser_pkg::*;
#(
    parameter int AD_COUNT = 6,
    parameter int ADDR_W   = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_act,
    input  logic                  sclk_f,
    input  logic                  sdi_f,
    input  logic [AD_COUNT*8-1:0] ad_bytes,
    output logic                  cmd_vld,
    output logic [7:0]            cmd_byte,
    output logic                  ram_we,
    output logic [ADDR_W-1:0]     ram_addr,
    output logic [7:0]            ram_wdata,
    output logic                  sdo,
    output logic                  sdo_en
);
    localparam int IDX_W = $clog2(AD_COUNT + 1);

    frame_st_e         st;
    logic              sclk_q;
    logic [7:0]        rx_sh;
    logic [2:0]        bit_cnt;
    logic [ADDR_W-1:0] wr_ptr;
    logic [7:0]        tx_sh;
    logic [2:0]        tx_bit;
    logic [IDX_W-1:0]  ad_idx;
    logic [7:0]        ad_next;
    logic [7:0]        rx_nxt;
    logic              rise, fall;

    assign rise   = sclk_f & ~sclk_q;
    assign fall   = ~sclk_f & sclk_q;
    assign rx_nxt = {sdi_f, rx_sh[7:1]};

    always_comb begin
        ad_next = '0;
        for (int k = 0; k < AD_COUNT; k++)
            if (ad_idx == IDX_W'(k))
                ad_next = ad_bytes[k*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FR_CMD;
            sclk_q    <= 1'b1;
            rx_sh     <= '0;
            bit_cnt   <= '0;
            wr_ptr    <= '0;
            tx_sh     <= '0;
            tx_bit    <= '0;
            ad_idx    <= '0;
            cmd_vld   <= 1'b0;
            cmd_byte  <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
            sdo       <= 1'b0;
            sdo_en    <= 1'b0;
        end else begin
            sclk_q  <= sclk_f;
            cmd_vld <= 1'b0;
            ram_we  <= 1'b0;
            sdo_en  <= cs_act;
            if (!cs_act) begin
                st      <= FR_CMD;
                bit_cnt <= '0;
                sdo     <= 1'b0;
            end else begin
                if (rise) begin
                    rx_sh   <= rx_nxt;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        case (st)
                            FR_CMD: begin
                                cmd_vld  <= 1'b1;
                                cmd_byte <= rx_nxt;
                                if (decode_header(rx_nxt) == CMD_DISP) begin
                                    st     <= FR_DATA;
                                    wr_ptr <= '0;
                                    tx_sh  <= ad_bytes[7:0];
                                    tx_bit <= '0;
                                    ad_idx <= IDX_W'(1);
                                end else begin
                                    st <= FR_SKIP;
                                end
                            end
                            FR_DATA: begin
                                ram_we    <= 1'b1;
                                ram_addr  <= wr_ptr;
                                ram_wdata <= rx_nxt;
                                wr_ptr    <= wr_ptr + ADDR_W'(1);
                            end
                            default: ;
                        endcase
                    end
                end
                if (fall && st == FR_DATA) begin
                    sdo    <= tx_sh[tx_bit];
                    tx_bit <= tx_bit + 3'd1;
                    if (tx_bit == 3'd7) begin
                        tx_sh <= ad_next;
                        if (ad_idx != IDX_W'(AD_COUNT))
                            ad_idx <= ad_idx + IDX_W'(1);
                    end
                end
            end
        end
    end

    // R1
    sdo_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !sdo_en);

    // R11
    frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (bit_cnt == 3'd0 && st == FR_CMD && !sdo));

    // R9
    skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == FR_SKIP) |=> (!cmd_vld && !ram_we));

    // R7
    write_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(st) == FR_DATA);

endmodule

// File: rtl/fld_cmd_regs.sv
module fld_cmd_regs
    import fld_ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_vld,
    input  logic [7:0] cmd_byte,
    output ctrl_regs_t regs
);
    cmd_kind_e kind;
    assign kind = decode_header(cmd_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (cmd_vld) begin
            case (kind)
                CMD_DISP: begin
                    regs.seg_wide <= cmd_byte[0];
                    regs.dig_cnt  <= cmd_byte[2:1];
                end
                CMD_STATE: begin
                    regs.disp_on <= cmd_byte[0];
                    regs.duty    <= cmd_byte[2:1];
                end
                CMD_DIGIT: regs.dig_start <= cmd_byte[3:0];
                CMD_PORT: begin
                    if (cmd_byte[4]) regs.port[7:4] <= cmd_byte[3:0];
                    else             regs.port[3:0] <= cmd_byte[3:0];
                end
                default: ;
            endcase
        end
    end

    // R6
    port_half_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && kind == CMD_PORT && !cmd_byte[4]) |=> regs.port[7:4] == $past(regs.port[7:4]));

    // R10
    unknown_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && kind == CMD_NONE) |=> regs == $past(regs));

endmodule

// File: rtl/fld_serial_ctrl.sv
module fld_serial_ctrl
    import fld_ser_pkg::*;
#(
    parameter int SAMPLE_DIV = 2,
    parameter int AD_COUNT   = 6,
    parameter int ADDR_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  sdi,
    input  logic [AD_COUNT*8-1:0] ad_bytes,
    output logic                  sdo,
    output logic                  sdo_en,
    output logic                  seg_wide,
    output logic [1:0]            dig_cnt,
    output logic                  disp_on,
    output logic [1:0]            duty,
    output logic [3:0]            dig_start,
    output logic [7:0]            port_out,
    output logic                  ram_we,
    output logic [ADDR_W-1:0]     ram_addr,
    output logic [7:0]            ram_wdata
);
    localparam int DIV_W = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic [1:0]       cs_sync;
    logic             cs_act;
    logic             sclk_f, sdi_f;
    logic             cmd_vld;
    logic [7:0]       cmd_byte;
    ctrl_regs_t       regs;

    assign tick   = (div_q == '0);
    assign cs_act = ~cs_sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            cs_sync <= 2'b11;
        end else begin
            div_q   <= (div_q == DIV_W'(SAMPLE_DIV - 1)) ? '0 : div_q + DIV_W'(1);
            cs_sync <= {cs_sync[0], cs_n};
        end
    end

    fld_in_filter #(.RST_VAL(1'b1)) u_flt_sclk (
        .clk(clk), .rst(rst), .tick(tick), .raw(sclk), .filt(sclk_f));

    fld_in_filter #(.RST_VAL(1'b0)) u_flt_sdi (
        .clk(clk), .rst(rst), .tick(tick), .raw(sdi), .filt(sdi_f));

    fld_ser_frame #(.AD_COUNT(AD_COUNT), .ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_f(sclk_f), .sdi_f(sdi_f),
        .ad_bytes(ad_bytes), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .sdo(sdo), .sdo_en(sdo_en));

    fld_cmd_regs u_regs (
        .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte), .regs(regs));

    assign seg_wide  = regs.seg_wide;
    assign dig_cnt   = regs.dig_cnt;
    assign disp_on   = regs.disp_on;
    assign duty      = regs.duty;
    assign dig_start = regs.dig_start;
    assign port_out  = regs.port;

endmodule

// File: tb/tb_fld_serial_ctrl.sv
module tb_fld_serial_ctrl;
    localparam int H = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
    logic [47:0] ad_bytes = 48'hC3_81_7E_0F_96_5A;
    logic        sdo, sdo_en, seg_wide, disp_on, ram_we;
    logic [1:0]  dig_cnt, duty;
    logic [3:0]  dig_start;
    logic [7:0]  port_out, ram_wdata;
    logic [5:0]  ram_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [13:0] exp_q[$];

    always #4 clk = ~clk;

    fld_serial_ctrl dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .ad_bytes(ad_bytes),
        .sdo(sdo), .sdo_en(sdo_en), .seg_wide(seg_wide), .dig_cnt(dig_cnt),
        .disp_on(disp_on), .duty(duty), .dig_start(dig_start), .port_out(port_out),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: every RAM write is matched against the scoreboard queue (R7)
    always @(negedge clk) begin
        if (!rst && ram_we) begin
            if (exp_q.size() == 0) chk("R7/R9 unexpected write", {18'd0, ram_addr, ram_wdata}, 32'hFFFF);
            else begin
                logic [13:0] e;
                e = exp_q.pop_front();
                chk("R7 ram write", {18'd0, ram_addr, ram_wdata}, {18'd0, e});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            report();
        end
    end

    task automatic shift_bits(input logic [7:0] b, input int n, input bit glitch, output logic [7:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0; sdi = b[i];
            if (glitch) begin
                repeat (5) @(negedge clk); sclk = 1'b1; @(negedge clk); sclk = 1'b0;
                repeat (H - 6) @(negedge clk);
            end else repeat (H) @(negedge clk);
            got[i] = sdo;
            sclk = 1'b1;
            if (glitch) begin
                repeat (5) @(negedge clk); sclk = 1'b0; @(negedge clk); sclk = 1'b1;
                repeat (H - 6) @(negedge clk);
            end else repeat (H) @(negedge clk);
        end
    endtask

    task automatic cs_open();
        @(negedge clk); cs_n = 1'b0; repeat (6) @(negedge clk);
    endtask

    task automatic cs_close();
        repeat (H) @(negedge clk); cs_n = 1'b1; repeat (8) @(negedge clk);
    endtask

    task automatic one_cmd(input logic [7:0] b, input bit glitch);
        logic [7:0] g;
        cs_open(); shift_bits(b, 8, glitch, g); cs_close();
    endtask

    function automatic logic [7:0] exp_ad(input int k);
        return (k < 6) ? ad_bytes[k*8 +: 8] : 8'h00;
    endfunction

    task automatic burst(input logic [7:0] cmd, input int n, input bit glitch, input logic [7:0] seed);
        logic [7:0] g, d;
        cs_open();
        shift_bits(cmd, 8, glitch, g);
        for (int k = 0; k < n; k++) begin
            d = seed ^ 8'(k * 37);
            exp_q.push_back({6'(k), d});
            shift_bits(d, 8, glitch, g);
            chk($sformatf("R8 sdo byte %0d", k), {24'd0, g}, {24'd0, exp_ad(k)});
        end
        cs_close();
    endtask

    initial begin
        logic [7:0] g;
        repeat (5) @(negedge clk);
        // R12 / R1: reset state
        chk("R1 sdo_en in reset", {31'd0, sdo_en}, 32'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R12 config after reset", {16'd0, seg_wide, dig_cnt, disp_on, duty, dig_start, port_out}, 32'd0);
        chk("R12 ram_we/sdo after reset", {30'd0, ram_we, sdo}, 32'd0);
        chk("R1 sdo_en cs high", {31'd0, sdo_en}, 32'd0);
        cs_open();
        chk("R1 sdo_en cs low", {31'd0, sdo_en}, 32'd1);
        cs_close();
        chk("R1 sdo_en after cs high", {31'd0, sdo_en}, 32'd0);

        // R4 + R3 + R9: state command then trailing bytes in the same frame
        cs_open();
        shift_bits(8'hC5, 8, 1'b0, g);
        shift_bits(8'hC0, 8, 1'b0, g);
        shift_bits(8'hE0, 8, 1'b0, g);
        cs_close();
        chk("R4 disp_on", {31'd0, disp_on}, 32'd1);
        chk("R4 R3 duty", {30'd0, duty}, 32'd2);
        chk("R9 trailing bytes ignored", {29'd0, seg_wide, dig_cnt}, 32'd0);

        // R5
        one_cmd(8'hAB, 1'b0);
        chk("R5 dig_start", {28'd0, dig_start}, 32'hB);

        // R6
        one_cmd(8'h86, 1'b0);
        chk("R6 port low half", {24'd0, port_out}, 32'h06);
        one_cmd(8'h99, 1'b0);
        chk("R6 port high half", {24'd0, port_out}, 32'h96);

        // R10
        one_cmd(8'h3F, 1'b0);
        chk("R10 unknown header", {16'd0, seg_wide, dig_cnt, disp_on, duty, dig_start, port_out}, {16'd0, 1'b0, 2'd0, 1'b1, 2'd2, 4'hB, 8'h96});

        // R11: partial byte then a clean frame
        cs_open(); shift_bits(8'hFF, 4, 1'b0, g); cs_close();
        chk("R11 partial byte no effect", {28'd0, disp_on, duty, 1'b0}, {28'd0, 1'b1, 2'd2, 1'b0});
        one_cmd(8'hC2, 1'b0);
        chk("R11 next frame decoded", {29'd0, disp_on, duty}, {29'd0, 1'b0, 2'd1});

        // R7 / R8: display burst past the defined result range
        burst(8'hE7, 8, 1'b0, 8'h3C);
        chk("R7 seg_wide", {31'd0, seg_wide}, 32'd1);
        chk("R7 dig_cnt", {30'd0, dig_cnt}, 32'd3);
        chk("R7 all writes seen", exp_q.size(), 32'd0);

        // R2 + R7: spiked clock, address restarts at zero
        burst(8'hE2, 3, 1'b1, 8'hA1);
        chk("R2 R7 glitch burst dig_cnt", {29'd0, seg_wide, dig_cnt}, {29'd0, 1'b0, 2'd1});
        chk("R2 R7 all writes seen", exp_q.size(), 32'd0);
        one_cmd(8'hAC ^ 8'h06, 1'b1);
        chk("R2 glitch command", {28'd0, dig_start}, 32'hA);

        done = 1;
        report();
    end
endmodule